// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block collects the wake requests of a network interface and turns them into a single active-low power-management event line for the host. Three sources can request a wake. The first is the re-establishment of the PHY link, seen as a rising edge of the link status. The second is a one-cycle hit from the magic-packet detector. The third is a one-cycle hit from the wakeup-frame pattern detector. Each source has its own qualifying conditions, built from the configuration enables and from a flag that says whether the device is isolated or allowed to raise the event in its current power state.

An accepted wake sets a sticky bit in a three-bit status word. The event line stays low while any status bit is set. Software clears individual bits by writing ones under a mask. The block also forms the power-management capability word that the host reads. It passes the stored word through when auxiliary power is present. When auxiliary power is absent, it clears the bits that advertise wake support from the cold off state.

Top module: `pm_wake_ctrl`

## Requirements
- R1: With `aux_present` = 1, `cap_host` equals `cap_stored` bit for bit.
- R2: With `aux_present` = 0, `cap_host` equals `cap_stored` with bits 15, 14, 7 and 0 forced to 0, so that C2F7 and C277 both read as 0276.
- R3: A low-to-high change of `phy_link_up` sets `wake_status[0]` (link) on the third rising clock edge after the change, provided `cfg_pme_en`, `cfg_link_wake_en` and `pme_allowed` are all 1. The status bit is not set after only two edges.
- R4: A link wake does not happen if `cfg_link_wake_en` or `pme_allowed` is 0, and a high-to-low change of the link never causes a wake.
- R5: A `magic_hit` pulse sets `wake_status[1]` (magic) on the same clock edge at which it is sampled, provided `cfg_pme_en`, `cfg_magic_wake_en` and `pme_allowed` are all 1.
- R6: A `magic_hit` pulse is ignored if `cfg_magic_wake_en` or `pme_allowed` is 0.
- R7: A `frame_hit` pulse sets `wake_status[2]` (frame) on the edge at which it is sampled whenever `cfg_pme_en` = 1, regardless of `pme_allowed`, `cfg_magic_wake_en` and `cfg_link_wake_en`.
- R8: While `cfg_pme_en` = 0, no source sets any status bit and `pme_n` stays 1.
- R9: `pme_n` is 0 exactly when at least one status bit is set. A set bit stays set until it is cleared.
- R10: A cycle with `clr_wr` = 1 clears exactly the status bits whose `clr_mask` bit is 1. If a bit is set by a qualified wake in the same cycle in which it is cleared, the set wins.
- R11: After reset, `wake_status` is 000 and `pme_n` is 1. Wakes are accepted only after the reset release has passed through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_stored | input | 16 | Capability word loaded from non-volatile storage |
| aux_present | input | 1 | Auxiliary power present |
| cfg_pme_en | input | 1 | Master enable for power-management events |
| cfg_link_wake_en | input | 1 | Enable for wake on link re-establishment |
| cfg_magic_wake_en | input | 1 | Enable for wake on magic packet |
| pme_allowed | input | 1 | Device isolated or event allowed in current power state |
| phy_link_up | input | 1 | Asynchronous PHY link status |
| magic_hit | input | 1 | One-cycle pulse from the magic-packet detector |
| frame_hit | input | 1 | One-cycle pulse from the wakeup-frame detector |
| clr_wr | input | 1 | Write strobe for clearing status bits |
| clr_mask | input | 3 | Bits to clear: [0] link, [1] magic, [2] frame |
| cap_host | output | 16 | Capability word presented to the host |
| wake_status | output | 3 | Sticky wake causes: [0] link, [1] magic, [2] frame |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The hardest case to reach from the ports is a clear that collides with a new qualified wake of the same source. The strobe and the detector pulse must fall into the very same clock cycle. The stimulus does this by driving `magic_hit` together with `clr_wr` and a matching mask on one falling edge, with the magic bit already set. It then checks that the bit survived and that `pme_n` stayed low.

A second hard case is the link latency, which only shows at the exact edges. The bench raises the link on a falling edge and checks status after two edges, where it must still be clear, and after three edges, where it must be set. It then drops the link and confirms that no new bit appears.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_LINK  = 0;
  localparam int SRC_MAGIC = 1;
  localparam int SRC_FRAME = 2;
  typedef logic [NUM_SRC-1:0] wake_vec_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_cap_mask.sv
module pm_cap_mask #(
  parameter int          CAP_W    = 16,
  parameter logic [15:0] CLR_BITS = 16'hC081
) (
  input  logic [CAP_W-1:0] cap_in,
  input  logic             aux_ok,
  output logic [CAP_W-1:0] cap_out
);
  localparam logic [CAP_W-1:0] KEEP = ~CAP_W'(CLR_BITS);

  always_comb begin
    if (aux_ok) cap_out = cap_in;
    else        cap_out = cap_in & KEEP;
  end
endmodule

// File: rtl/pm_link_rise.sv
module pm_link_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_async,
  output logic link_rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb sync_d[s] = link_async;
      end else begin : g_next
        always_comb sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  always_comb begin
    prev_d    = sync_q[STAGES-1];
    link_rise = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status
  import pm_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wake_vec_t set_vec,
  input  logic      clr_wr,
  input  wake_vec_t clr_mask,
  output wake_vec_t status,
  output logic      pme_n
);
  wake_vec_t stat_q, stat_d;
  logic      pme_q, pme_d;
  logic      upd_en;

  always_comb begin
    upd_en = clr_wr | (|set_vec);
    stat_d = stat_q;
    if (clr_wr) stat_d = stat_d & ~clr_mask;
    stat_d = stat_d | set_vec;
    pme_d  = ~(|stat_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pme_q  <= 1'b1;
    end else if (upd_en) begin
      stat_q <= stat_d;
      pme_q  <= pme_d;
    end
  end

  assign status = stat_q;
  assign pme_n  = pme_q;
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int          CAP_W       = 16,
  parameter logic [15:0] CAP_CLR     = 16'hC081,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap_stored,
  input  logic             aux_present,
  input  logic             cfg_pme_en,
  input  logic             cfg_link_wake_en,
  input  logic             cfg_magic_wake_en,
  input  logic             pme_allowed,
  input  logic             phy_link_up,
  input  logic             magic_hit,
  input  logic             frame_hit,
  input  logic             clr_wr,
  input  logic [2:0]       clr_mask,
  output logic [CAP_W-1:0] cap_host,
  output logic [2:0]       wake_status,
  output logic             pme_n
);
  logic      rst_int_n;
  logic      link_rise;
  wake_vec_t set_vec;
  wake_vec_t stat_w;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  pm_cap_mask #(.CAP_W(CAP_W), .CLR_BITS(CAP_CLR)) u_cap (
    .cap_in(cap_stored), .aux_ok(aux_present), .cap_out(cap_host)
  );

  pm_link_rise #(.STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_int_n), .link_async(phy_link_up), .link_rise(link_rise)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_LINK]  = cfg_pme_en & cfg_link_wake_en  & pme_allowed & link_rise;
    set_vec[SRC_MAGIC] = cfg_pme_en & cfg_magic_wake_en & pme_allowed & magic_hit;
    set_vec[SRC_FRAME] = cfg_pme_en & frame_hit;
  end

  pm_wake_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .set_vec(set_vec),
    .clr_wr(clr_wr), .clr_mask(wake_vec_t'(clr_mask)),
    .status(stat_w), .pme_n(pme_n)
  );

  assign wake_status = stat_w;
endmodule

// File: rtl/pm_wake_ctrl_chk.sv
module pm_wake_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cap_stored,
  input logic        aux_present,
  input logic [15:0] cap_host,
  input logic        cfg_pme_en,
  input logic        cfg_link_wake_en,
  input logic        cfg_magic_wake_en,
  input logic        pme_allowed,
  input logic        magic_hit,
  input logic        frame_hit,
  input logic        clr_wr,
  input logic [2:0]  clr_mask,
  input logic [2:0]  wake_status,
  input logic        pme_n
);
  always_comb begin
    if (!aux_present) assert ((cap_host & 16'hC081) == 16'h0000); // R2
    if (aux_present)  assert (cap_host == cap_stored); // R1
  end

  AST_LINK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_status[0]) |-> $past(cfg_pme_en && cfg_link_wake_en && pme_allowed)); // R4
  AST_MAGIC_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_status[1]) |-> $past(magic_hit && cfg_pme_en && cfg_magic_wake_en && pme_allowed)); // R6
  AST_FRAME_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_status[2]) |-> $past(frame_hit && cfg_pme_en)); // R7
  AST_PME_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    pme_n == (wake_status == 3'b000)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((wake_status & $past(wake_status)) == $past(wake_status))); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[1] && magic_hit && cfg_pme_en && cfg_magic_wake_en && pme_allowed)
      |=> wake_status[1]); // R10
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_stored(cap_stored), .aux_present(aux_present),
  .cap_host(cap_host), .cfg_pme_en(cfg_pme_en), .cfg_link_wake_en(cfg_link_wake_en),
  .cfg_magic_wake_en(cfg_magic_wake_en), .pme_allowed(pme_allowed),
  .magic_hit(magic_hit), .frame_hit(frame_hit), .clr_wr(clr_wr), .clr_mask(clr_mask),
  .wake_status(wake_status), .pme_n(pme_n)
);

// File: tb/pm_wake_ctrl_bench.sv
module pm_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cap_stored;
  logic        aux_present, cfg_pme_en, cfg_link_wake_en, cfg_magic_wake_en;
  logic        pme_allowed, phy_link_up, magic_hit, frame_hit, clr_wr;
  logic [2:0]  clr_mask;
  logic [15:0] cap_host;
  logic [2:0]  wake_status;
  logic        pme_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pm_wake_ctrl u_pm_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_stored(cap_stored), .aux_present(aux_present),
    .cfg_pme_en(cfg_pme_en), .cfg_link_wake_en(cfg_link_wake_en),
    .cfg_magic_wake_en(cfg_magic_wake_en), .pme_allowed(pme_allowed),
    .phy_link_up(phy_link_up), .magic_hit(magic_hit), .frame_hit(frame_hit),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .cap_host(cap_host),
    .wake_status(wake_status), .pme_n(pme_n)
  );

  // {aux_present, stored word, expected host word}
  localparam logic [32:0] CAP_VEC [8] = '{
    {1'b1, 16'hC2F7, 16'hC2F7},
    {1'b0, 16'hC2F7, 16'h0276},
    {1'b1, 16'hC277, 16'hC277},
    {1'b0, 16'hC277, 16'h0276},
    {1'b0, 16'hFFFF, 16'h3F7E},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h8001, 16'h0000},
    {1'b0, 16'h4080, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_magic();
    magic_hit = 1'b1; step(1); magic_hit = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_hit = 1'b1; step(1); frame_hit = 1'b0;
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_mask = 3'b111; step(1); clr_wr = 1'b0; clr_mask = 3'b000;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cap_stored = 16'h0; aux_present = 1'b0;
    cfg_pme_en = 1'b0; cfg_link_wake_en = 1'b0; cfg_magic_wake_en = 1'b0;
    pme_allowed = 1'b0; phy_link_up = 1'b0; magic_hit = 1'b0; frame_hit = 1'b0;
    clr_wr = 1'b0; clr_mask = 3'b000;
    step(3);
    check("R11 reset status", 32'(wake_status), 32'h0);
    check("R11 reset pme_n", 32'(pme_n), 32'h1);
    @(negedge clk); rst_n = 1'b1;
    step(4);

    // Capability word table: R1 and R2
    foreach (CAP_VEC[i]) begin
      aux_present = CAP_VEC[i][32];
      cap_stored  = CAP_VEC[i][31:16];
      #1;
      check(CAP_VEC[i][32] ? "R1 cap pass" : "R2 cap mask", 32'(cap_host), 32'(CAP_VEC[i][15:0]));
    end

    // R5 magic accepted, R9 sticky, R10 clear
    cfg_pme_en = 1'b1; cfg_magic_wake_en = 1'b1; pme_allowed = 1'b1;
    pulse_magic();
    check("R5 magic status", 32'(wake_status), 32'h2);
    check("R9 pme low", 32'(pme_n), 32'h0);
    step(5);
    check("R9 magic sticky", 32'(wake_status), 32'h2);
    clr_wr = 1'b1; clr_mask = 3'b101; step(1); clr_wr = 1'b0; clr_mask = 3'b000;
    check("R10 unmasked bit kept", 32'(wake_status), 32'h2);
    clear_all();
    check("R10 cleared", 32'(wake_status), 32'h0);
    check("R9 pme released", 32'(pme_n), 32'h1);

    // R6 magic blocked
    cfg_magic_wake_en = 1'b0; pulse_magic(); step(1);
    check("R6 magic disabled", 32'(wake_status), 32'h0);
    cfg_magic_wake_en = 1'b1; pme_allowed = 1'b0; pulse_magic(); step(1);
    check("R6 magic not allowed", 32'(wake_status), 32'h0);
    check("R6 pme idle", 32'(pme_n), 32'h1);

    // R7 frame needs only pme enable
    cfg_magic_wake_en = 1'b0; cfg_link_wake_en = 1'b0; pme_allowed = 1'b0;
    pulse_frame();
    check("R7 frame status", 32'(wake_status), 32'h4);
    clear_all();

    // R8 everything ignored with pme enable low
    cfg_pme_en = 1'b0; cfg_magic_wake_en = 1'b1; cfg_link_wake_en = 1'b1; pme_allowed = 1'b1;
    pulse_magic(); pulse_frame();
    phy_link_up = 1'b1; step(5);
    check("R8 no status", 32'(wake_status), 32'h0);
    check("R8 pme idle", 32'(pme_n), 32'h1);
    phy_link_up = 1'b0; step(4);

    // R3 link wake latency
    cfg_pme_en = 1'b1;
    phy_link_up = 1'b1; step(2);
    check("R3 link not yet", 32'(wake_status), 32'h0);
    step(1);
    check("R3 link set", 32'(wake_status), 32'h1);
    clear_all(); step(3);
    check("R3 steady link no rewake", 32'(wake_status), 32'h0);

    // R4 falling link and disabled link
    phy_link_up = 1'b0; step(5);
    check("R4 link fall", 32'(wake_status), 32'h0);
    cfg_link_wake_en = 1'b0; phy_link_up = 1'b1; step(5);
    check("R4 link disabled", 32'(wake_status), 32'h0);
    phy_link_up = 1'b0; step(4);
    cfg_link_wake_en = 1'b1; pme_allowed = 1'b0; phy_link_up = 1'b1; step(5);
    check("R4 link not allowed", 32'(wake_status), 32'h0);
    phy_link_up = 1'b0; pme_allowed = 1'b1; step(4);

    // R10 set wins over clear in the same cycle
    pulse_magic();
    magic_hit = 1'b1; clr_wr = 1'b1; clr_mask = 3'b010; step(1);
    magic_hit = 1'b0; clr_wr = 1'b0; clr_mask = 3'b000;
    check("R10 set wins", 32'(wake_status), 32'h2);
    check("R10 pme held", 32'(pme_n), 32'h0);
    pulse_frame();
    clr_wr = 1'b1; clr_mask = 3'b100; step(1); clr_wr = 1'b0; clr_mask = 3'b000;
    check("R10 partial clear", 32'(wake_status), 32'h2);

    // R11 reset mid-operation
    rst_n = 1'b0; step(1);
    check("R11 async reset status", 32'(wake_status), 32'h0);
    check("R11 async reset pme", 32'(pme_n), 32'h1);
    rst_n = 1'b1; step(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule